// File: doc/BRIEF.md
# DRAM Refresh Request Scheduler

This block paces DRAM refresh for a memory sequencer. It divides the processor clock down to a periodic refresh tick. The divider is a fixed divide-by-16 prescaler followed by a down-counter that reloads from a programmed rate value. The tick period is therefore 16 × (rate + 1) clocks. For example, a rate of 24 at 25 MHz gives one tick every 400 clocks, which is 16 µs.

Each tick adds one to a small count of refreshes that are owed. The sequencer answers each refresh with a one-cycle done pulse, and that pulse removes one from the count. A burst transfer is never cut short. While the sequencer reports a burst in progress, the request is held low and owed refreshes accumulate instead of being lost. The request rises as soon as the burst ends, so the device-wide refresh deadline still holds when single rows are postponed by a burst.

Accesses to targets other than the DRAM are not seen by this block and are never stalled by it.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted, `refresh_req` is 0 and `owed_count` is 0.
- R2: With the rate held at N, the owed count gains its first refresh on the 16·(N+1)-th rising clock edge after reset is released. Later refreshes arrive every 16·(N+1) edges after that.
- R3: Each refresh tick that has no accepted done pulse in the same cycle increases `owed_count` by exactly one.
- R4: A `refresh_done` pulse decreases `owed_count` by one when the count is nonzero. When the count is zero, the pulse is ignored and the count stays 0.
- R5: When a tick and an accepted done pulse fall in the same cycle, `owed_count` is unchanged.
- R6: `refresh_req` is 0 in every cycle where `burst_busy` is 1, so a refresh never interrupts a burst.
- R7: A refresh that was deferred by a burst is kept in `owed_count`. `refresh_req` is 1 in the first cycle that `burst_busy` is 0 and the count is nonzero.
- R8: A new rate value is used only at the next reload of the down-counter. The period already running completes at its old length.
- R9: `owed_count` saturates at 2^CNT_W − 1 (7 by default) and never wraps to 0.
- R10: A rate value of 0 gives one tick every 16 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_val | input | RATE_W | Programmed rate; the tick period is 16·(rate_val+1) clocks |
| burst_busy | input | 1 | High while the sequencer is running a burst transfer |
| refresh_done | input | 1 | One-cycle pulse from the sequencer when a refresh cycle completes |
| refresh_req | output | 1 | High when a refresh is owed and no burst is active |
| owed_count | output | CNT_W | Number of refreshes currently owed |

## Verification
The checker tests several properties on every cycle:
- the request is never raised during a burst;
- the owed count moves by at most one per cycle, never wraps at its ceiling, and cannot leave zero without a tick;
- every tick lines up with a prescaler pulse, and ticks are at least sixteen clocks apart.

Only the bench scenarios can confirm the exact tick period for a given rate, and that a rate change waits for the next reload. They also cover the same-cycle cancellation of a tick and a done pulse, and the draining of a backlog built up behind a long burst.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  // Next owed count from the current count, a tick and an accepted done.
  // Adds on a lone tick (saturating at max_v), subtracts on a lone done,
  // and holds when both or neither occur.
  function automatic int unsigned owed_step(int unsigned cur, int unsigned max_v,
                                            logic inc, logic dec);
    if (inc && !dec) return (cur < max_v) ? cur + 1 : max_v;
    if (dec && !inc) return (cur > 0) ? cur - 1 : 0;
    return cur;
  endfunction

  // The rate counter reloads when a prescaler step finds it at zero.
  function automatic logic reload_due(int unsigned cnt, logic step);
    return step && (cnt == 0);
  endfunction

endpackage

// File: rtl/rfsh_prescaler.sv
module rfsh_prescaler #(
  parameter int PRE_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic pulse
);
  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  // One pulse per 2**PRE_W clocks, in the last state of the cycle.
  assign pulse = &cnt_q;
endmodule

// File: rtl/rfsh_rate_ctr.sv
module rfsh_rate_ctr #(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [RATE_W-1:0] rate_val,
  output logic              tick
);
  import rfsh_pkg::*;

  logic [RATE_W-1:0] cnt_q;
  logic              loaded_q;
  logic              reload;

  assign reload = loaded_q && reload_due(32'(cnt_q), step);
  assign tick   = reload;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      loaded_q <= 1'b0;
    end else if (!loaded_q) begin
      // First clock after reset: take the programmed rate.
      cnt_q    <= rate_val;
      loaded_q <= 1'b1;
    end else if (reload) begin
      // A new rate is picked up only here, at the reload.
      cnt_q <= rate_val;
    end else if (step) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rfsh_owed_ctr.sv
module rfsh_owed_ctr #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec_req,
  output logic             dec_fire,
  output logic [CNT_W-1:0] owed
);
  import rfsh_pkg::*;

  localparam int unsigned OWED_MAX = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] owed_q;

  // A done pulse counts only when something is owed.
  assign dec_fire = dec_req && (owed_q != '0);
  assign owed     = owed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) owed_q <= '0;
    else        owed_q <= CNT_W'(owed_step(32'(owed_q), OWED_MAX, inc, dec_fire));
  end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int RATE_W = 8,
  parameter int PRE_W  = 4,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_val,
  input  logic              burst_busy,
  input  logic              refresh_done,
  output logic              refresh_req,
  output logic [CNT_W-1:0]  owed_count
);
  // Internal events, brought out as named wires for the checker.
  logic pre_pulse;
  logic rate_tick;
  logic done_accept;

  rfsh_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .pulse (pre_pulse)
  );

  rfsh_rate_ctr #(.RATE_W(RATE_W)) u_rate (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (pre_pulse),
    .rate_val (rate_val),
    .tick     (rate_tick)
  );

  rfsh_owed_ctr #(.CNT_W(CNT_W)) u_owed (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (rate_tick),
    .dec_req  (refresh_done),
    .dec_fire (done_accept),
    .owed     (owed_count)
  );

  // Request only while something is owed and no burst is running.
  assign refresh_req = (owed_count != '0) && !burst_busy;
endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk #(
  parameter int PRE_W = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             burst_busy,
  input logic             refresh_done,
  input logic             refresh_req,
  input logic [CNT_W-1:0] owed_count,
  input logic             rate_tick,
  input logic             pre_pulse
);
  localparam logic [CNT_W-1:0] OWED_MAX = '1;
  localparam int MIN_GAP = (1 << PRE_W) - 1;

  int gap_q;
  bit seen_q;

  // Cycles since the last tick, counted here rather than with $past.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q  <= 0;
      seen_q <= 1'b0;
    end else if (rate_tick) begin
      gap_q  <= 0;
      seen_q <= 1'b1;
    end else if (gap_q < MIN_GAP + 1) begin
      gap_q <= gap_q + 1;
    end
  end

  AST_NO_REQ_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    burst_busy |-> !refresh_req); // R6

  AST_REQ_AFTER_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (owed_count != '0 && !burst_busy) |-> refresh_req); // R7

  AST_OWED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (owed_count == $past(owed_count)) ||
             (owed_count == $past(owed_count) + 1'b1) ||
             (owed_count + 1'b1 == $past(owed_count))); // R3

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (owed_count == OWED_MAX && !refresh_done) |=> owed_count == OWED_MAX); // R9

  AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (owed_count == '0 && !rate_tick) |=> owed_count == '0); // R4

  AST_TICK_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rate_tick |-> pre_pulse); // R2

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_tick && seen_q) |-> gap_q >= MIN_GAP); // R10
endmodule

bind dram_refresh_sched rfsh_sched_chk #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .burst_busy   (burst_busy),
  .refresh_done (refresh_done),
  .refresh_req  (refresh_req),
  .owed_count   (owed_count),
  .rate_tick    (rate_tick),
  .pre_pulse    (pre_pulse)
);

// File: tb/sim_dram_refresh_sched.sv
module sim_dram_refresh_sched;
  localparam int OWED_MAX = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rate_val = 8'd2;
  logic       burst_busy = 1'b0;
  logic       refresh_done = 1'b0;
  logic       refresh_req;
  logic [2:0] owed_count;

  always #4 clk = ~clk;

  dram_refresh_sched u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .rate_val     (rate_val),
    .burst_busy   (burst_busy),
    .refresh_done (refresh_done),
    .refresh_req  (refresh_req),
    .owed_count   (owed_count)
  );

  int    checks = 0;
  int    fails = 0;
  bit    finished = 0;
  string tag = "R3";
  int    left = 0;

  // Reference model of the owed count, built from the requirements.
  int edges = 0;
  int next_tick = 0;
  int exp_owed = 0;
  bit last_both = 0;

  // Tick period in clocks for a given rate value.
  function automatic int period_of(logic [7:0] r);
    return 16 * (int'(r) + 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      edges = 0; next_tick = 0; exp_owed = 0; last_both = 0;
    end else begin
      bit t, d;
      edges++;
      if (edges == 1) next_tick = period_of(rate_val);
      t = (edges == next_tick);
      if (t) next_tick = edges + period_of(rate_val);
      d = refresh_done && (exp_owed > 0);
      last_both = t && d;
      if (t && !d) exp_owed = (exp_owed < OWED_MAX) ? exp_owed + 1 : OWED_MAX;
      else if (d && !t) exp_owed = exp_owed - 1;
    end
  end

  task automatic chk(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  task automatic cyc_check();
    chk(last_both ? "R5 owed" : {tag, " owed"}, int'(owed_count), exp_owed);
    chk("R6 req", int'(refresh_req), int'(exp_owed != 0 && !burst_busy));
  endtask

  // Random bursts of 1..6 cycles and done pulses from a sequencer model.
  task automatic traffic(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc_check();
      refresh_done = 1'b0;
      if (left > 0) left--;
      if (left == 0) begin
        burst_busy = 1'b0;
        if ($urandom_range(7) == 0) begin
          left = $urandom_range(6, 1);
          burst_busy = 1'b1;
        end
      end
      if (!burst_busy) begin
        if (exp_owed != 0 && $urandom_range(2) == 0) refresh_done = 1'b1;
        else if ($urandom_range(15) == 0) refresh_done = 1'b1;
      end
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1 req in reset", int'(refresh_req), 0);
    chk("R1 owed in reset", int'(owed_count), 0);
    rst_n = 1'b1;

    // First and second tick with rate 2: edges 48 and 96.
    repeat (47) @(negedge clk);
    chk("R2 before first tick", int'(owed_count), 0);
    @(negedge clk);
    chk("R2 first tick", int'(owed_count), 1);
    repeat (47) @(negedge clk);
    chk("R2 before second tick", int'(owed_count), 1);
    @(negedge clk);
    chk("R2 second tick", int'(owed_count), 2);

    tag = "R3";  traffic(3000);
    tag = "R8";  rate_val = 8'd9;  traffic(500);
    rate_val = 8'd30; traffic(1500);
    rate_val = 8'd1;  traffic(600);
    tag = "R10"; rate_val = 8'd0; traffic(1000);

    // Long burst: backlog builds to the ceiling and the request stays low.
    tag = "R9";
    @(negedge clk); cyc_check();
    left = 0; refresh_done = 1'b0; burst_busy = 1'b1;
    repeat (150) begin @(negedge clk); cyc_check(); end
    chk("R9 saturated", int'(owed_count), OWED_MAX);
    chk("R6 held during burst", int'(refresh_req), 0);
    burst_busy = 1'b0;
    #1 chk("R7 request after burst", int'(refresh_req), 1);

    // Drain with done held high, including done while nothing is owed.
    tag = "R4"; rate_val = 8'd200;
    repeat (20) begin
      @(negedge clk); cyc_check();
      refresh_done = 1'b1;
    end
    @(negedge clk); cyc_check();
    refresh_done = 1'b0;

    tag = "R3"; rate_val = 8'd24; traffic(6000);

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule